// File: doc/BRIEF.md
# Banked System Control Register

This block holds the 32-bit system control word of a processor with two security states. It keeps one copy of the configuration bits for the Secure state and another for the Non-secure state, plus a Secure-only replacement-policy bit and a strap-fixed interrupt configuration bit. The copy that matches the current security state drives the MMU enable, alignment check, cache enables, branch prediction, high-vector select, exception endianness, remap, access-flag and exception instruction-set outputs. The selected exception vector base is driven as well.

Software reaches the register through a single-cycle access strobe with a read/write flag and write data. Every access is checked against the current privilege level, the security state and a configuration lock pin. Accesses that are not allowed set an undefined-instruction flag and change no state. Read data and the flag are registered. Reset is synchronous and active high, and it seeds several bits from strap inputs.

Top module: `sysctl_reg`

## Requirements
- R1: On reset both copies load exception instruction-set state (bit 30) from `strap_tstate`, exception endianness (bit 25) from `strap_bigend` and high vectors (bit 13) from `strap_hivec`. Bit 27 loads from `strap_nmi`. All other stored bits, including the replacement policy (bit 14), reset to 0.
- R2: Bits 23, 22, 18, 16 and 6 to 3 always read 1 (mask 0x00C50078). Every bit outside those and outside bits 30, 29, 28, 27, 25, 14, 13, 12, 11, 10, 2, 1, 0 always reads 0. Writes to any of these bits have no effect.
- R3: Bit 27 is read-only. It holds its strap value no matter what software writes to it.
- R4: Bit 14 (0 = random, 1 = round-robin) is written only by a legal Secure access. Non-secure writes leave it unchanged. Reads in both states return the single Secure value, and `rr_policy` always shows it.
- R5: Bits 30, 29, 28, 25, 13, 12, 11, 10, 2, 1, 0 exist once per state. A legal write updates only the copy named by `secure` (1 = Secure), and a read returns that copy.
- R6: An access with `priv` low, in either state, sets `undef` in the next cycle, returns read data 0 and changes no state.
- R7: A write with `priv` high, `secure` high and `lock` high sets `undef` and is not performed. `lock` does not block Non-secure writes or any read.
- R8: `vec_base` is 0x00000000 when the current copy's bit 13 is 0 and 0xFFFF0000 when it is 1.
- R9: `rd_data` and `undef` are valid in the cycle after the strobe. A write takes effect at the strobe's clock edge. After a cycle with no legal read, `rd_data` is 0. After a cycle with no illegal access, `undef` is 0.
- R10: The control outputs follow the copy for the current `secure` value: `mmu_en` bit 0, `align_chk` bit 1, `dcache_en` bit 2, `bpred_en` bit 11, `icache_en` bit 12, `hi_vec` bit 13, `exc_bigend` bit 25, `remap_en` bit 28, `afe_en` bit 29, `exc_tstate` bit 30.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Access strobe, one cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_wdata | input | 32 | Write data |
| priv | input | 1 | 1 = privileged mode |
| secure | input | 1 | 1 = Secure state |
| lock | input | 1 | Blocks Secure writes when high |
| strap_tstate | input | 1 | Reset value of bit 30 |
| strap_bigend | input | 1 | Reset value of bit 25 |
| strap_hivec | input | 1 | Reset value of bit 13 |
| strap_nmi | input | 1 | Value of read-only bit 27 |
| rd_data | output | 32 | Registered read data |
| undef | output | 1 | Registered illegal-access flag |
| mmu_en | output | 1 | MMU enable of current copy |
| align_chk | output | 1 | Strict alignment check |
| dcache_en | output | 1 | Data cache enable |
| icache_en | output | 1 | Instruction cache enable |
| bpred_en | output | 1 | Branch prediction enable |
| hi_vec | output | 1 | High vectors selected |
| exc_bigend | output | 1 | Endianness on exception entry |
| remap_en | output | 1 | Memory attribute remap enable |
| afe_en | output | 1 | Access-flag enable |
| exc_tstate | output | 1 | Exception instruction-set state |
| rr_policy | output | 1 | Secure replacement policy |
| vec_base | output | 32 | Exception vector base |

## Verification
The hardest situation to reach is a divergence between the two copies that persists while illegal and locked accesses hit them. Only that case shows whether a write leaked into the wrong bank or slipped past the gate. The stimulus first fills the Secure copy with all ones and the Non-secure copy with a sparse pattern. It then issues unprivileged and locked writes of opposite data in both states, and finally reads and samples outputs under both `secure` values. A second reset with inverted straps separates strap-seeded bits from constant ones.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
    localparam int REG_W = 32;
    localparam int NBANK = 2;

    localparam int B_TE   = 30;
    localparam int B_AFE  = 29;
    localparam int B_TRE  = 28;
    localparam int B_NMI  = 27;
    localparam int B_EE   = 25;
    localparam int B_RR   = 14;
    localparam int B_V    = 13;
    localparam int B_I    = 12;
    localparam int B_Z    = 11;
    localparam int B_SW   = 10;
    localparam int B_C    = 2;
    localparam int B_A    = 1;
    localparam int B_M    = 0;

    localparam logic [REG_W-1:0] ONES_MASK = 32'h00C5_0078;
    localparam logic [REG_W-1:0] LIVE_MASK =
        (32'd1 << B_TE) | (32'd1 << B_AFE) | (32'd1 << B_TRE) | (32'd1 << B_NMI) |
        (32'd1 << B_EE) | (32'd1 << B_RR)  | (32'd1 << B_V)   | (32'd1 << B_I)   |
        (32'd1 << B_Z)  | (32'd1 << B_SW)  | (32'd1 << B_C)   | (32'd1 << B_A)   |
        (32'd1 << B_M);
    localparam logic [REG_W-1:0] ZERO_MASK = ~(ONES_MASK | LIVE_MASK);

    typedef struct packed {
        logic te;
        logic afe;
        logic tre;
        logic ee;
        logic v;
        logic icache;
        logic bpred;
        logic swp;
        logic dcache;
        logic align;
        logic mmu;
    } bank_t;

    typedef struct packed {
        logic wr_ok;
        logic rd_ok;
        logic trap;
    } gate_t;

    function automatic bank_t word_to_bank(input logic [REG_W-1:0] w);
        bank_t b;
        b.te     = w[B_TE];
        b.afe    = w[B_AFE];
        b.tre    = w[B_TRE];
        b.ee     = w[B_EE];
        b.v      = w[B_V];
        b.icache = w[B_I];
        b.bpred  = w[B_Z];
        b.swp    = w[B_SW];
        b.dcache = w[B_C];
        b.align  = w[B_A];
        b.mmu    = w[B_M];
        return b;
    endfunction

    function automatic logic [REG_W-1:0] bank_to_word(input bank_t b);
        logic [REG_W-1:0] w;
        w        = '0;
        w[B_TE]  = b.te;
        w[B_AFE] = b.afe;
        w[B_TRE] = b.tre;
        w[B_EE]  = b.ee;
        w[B_V]   = b.v;
        w[B_I]   = b.icache;
        w[B_Z]   = b.bpred;
        w[B_SW]  = b.swp;
        w[B_C]   = b.dcache;
        w[B_A]   = b.align;
        w[B_M]   = b.mmu;
        return w;
    endfunction
endpackage

// File: rtl/sysctl_gate.sv
module sysctl_gate
    import sysctl_pkg::*;
(
    input  logic  acc_valid,
    input  logic  acc_write,
    input  logic  priv,
    input  logic  secure,
    input  logic  lock,
    output gate_t verdict
);
    logic locked_wr;

    always_comb begin
        locked_wr       = acc_write && secure && lock;
        verdict.trap    = acc_valid && (!priv || locked_wr);
        verdict.wr_ok   = acc_valid && acc_write && priv && !locked_wr;
        verdict.rd_ok   = acc_valid && !acc_write && priv;
    end
endmodule

// File: rtl/sysctl_view.sv
module sysctl_view
    import sysctl_pkg::*;
(
    input  bank_t             cur,
    input  logic              rr,
    input  logic              nmi,
    output logic [REG_W-1:0]  word
);
    logic [REG_W-1:0] single;

    always_comb begin
        single         = '0;
        single[B_RR]   = rr;
        single[B_NMI]  = nmi;
        word           = ONES_MASK | bank_to_word(cur) | single;
    end
endmodule

// File: rtl/sysctl_vecsel.sv
module sysctl_vecsel #(
    parameter int          AW     = 32,
    parameter logic [AW-1:0] BASE_LO = '0,
    parameter logic [AW-1:0] BASE_HI = {{(AW/2){1'b1}}, {(AW - AW/2){1'b0}}}
) (
    input  logic          hi,
    output logic [AW-1:0] base
);
    always_comb base = hi ? BASE_HI : BASE_LO;
endmodule

// File: rtl/sysctl_reg.sv
module sysctl_reg
    import sysctl_pkg::*;
#(
    parameter logic [31:0] VEC_LO = 32'h0000_0000,
    parameter logic [31:0] VEC_HI = 32'hFFFF_0000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        acc_valid,
    input  logic        acc_write,
    input  logic [31:0] acc_wdata,
    input  logic        priv,
    input  logic        secure,
    input  logic        lock,
    input  logic        strap_tstate,
    input  logic        strap_bigend,
    input  logic        strap_hivec,
    input  logic        strap_nmi,
    output logic [31:0] rd_data,
    output logic        undef,
    output logic        mmu_en,
    output logic        align_chk,
    output logic        dcache_en,
    output logic        icache_en,
    output logic        bpred_en,
    output logic        hi_vec,
    output logic        exc_bigend,
    output logic        remap_en,
    output logic        afe_en,
    output logic        exc_tstate,
    output logic        rr_policy,
    output logic [31:0] vec_base
);
    typedef struct packed {
        bank_t [NBANK-1:0] bank;
        logic              rr;
        logic              nmi;
        logic [REG_W-1:0]  rdata;
        logic              trap;
    } state_t;

    state_t s_d, s_q, s_rst;
    gate_t  verdict;
    bank_t  cur, wr_img;
    logic [REG_W-1:0] view;

    sysctl_gate u_gate (
        .acc_valid (acc_valid),
        .acc_write (acc_write),
        .priv      (priv),
        .secure    (secure),
        .lock      (lock),
        .verdict   (verdict)
    );

    assign cur    = s_q.bank[secure];
    assign wr_img = word_to_bank(acc_wdata);

    sysctl_view u_view (
        .cur  (cur),
        .rr   (s_q.rr),
        .nmi  (s_q.nmi),
        .word (view)
    );

    sysctl_vecsel #(
        .AW      (32),
        .BASE_LO (VEC_LO),
        .BASE_HI (VEC_HI)
    ) u_vec (
        .hi   (cur.v),
        .base (vec_base)
    );

    // Reset image: every copy starts from the same straps.
    always_comb begin
        s_rst = '0;
        for (int b = 0; b < NBANK; b++) begin
            s_rst.bank[b].te = strap_tstate;
            s_rst.bank[b].ee = strap_bigend;
            s_rst.bank[b].v  = strap_hivec;
        end
        s_rst.nmi = strap_nmi;
    end

    always_comb begin
        s_d       = s_q;
        s_d.trap  = verdict.trap;
        s_d.rdata = verdict.rd_ok ? view : '0;
        for (int b = 0; b < NBANK; b++) begin
            if (verdict.wr_ok && (secure == 1'(b)))
                s_d.bank[b] = wr_img;
        end
        if (verdict.wr_ok && secure)
            s_d.rr = acc_wdata[B_RR];
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= s_rst;
        else     s_q <= s_d;
    end

    assign rd_data    = s_q.rdata;
    assign undef      = s_q.trap;
    assign rr_policy  = s_q.rr;
    assign mmu_en     = cur.mmu;
    assign align_chk  = cur.align;
    assign dcache_en  = cur.dcache;
    assign icache_en  = cur.icache;
    assign bpred_en   = cur.bpred;
    assign hi_vec     = cur.v;
    assign exc_bigend = cur.ee;
    assign remap_en   = cur.tre;
    assign afe_en     = cur.afe;
    assign exc_tstate = cur.te;
endmodule

// File: rtl/sysctl_reg_chk.sv
module sysctl_reg_chk
    import sysctl_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        acc_valid,
    input logic        acc_write,
    input logic        priv,
    input logic        secure,
    input logic        lock,
    input logic [31:0] rd_data,
    input logic        undef,
    input logic        rr_policy
);
    AST_USER_TRAPS: assert property (@(posedge clk) disable iff (rst)
        acc_valid && !priv |=> undef && rd_data == '0); // R6

    AST_USER_RR_HOLDS: assert property (@(posedge clk) disable iff (rst)
        acc_valid && !priv |=> $stable(rr_policy)); // R6

    AST_LOCKED_WRITE_TRAPS: assert property (@(posedge clk) disable iff (rst)
        acc_valid && acc_write && priv && secure && lock |=> undef); // R7

    AST_ONES_FIELD: assert property (@(posedge clk) disable iff (rst)
        acc_valid && !acc_write && priv |=> (rd_data & ONES_MASK) == ONES_MASK); // R2

    AST_ZERO_FIELD: assert property (@(posedge clk) disable iff (rst)
        acc_valid |=> (rd_data & ZERO_MASK) == '0); // R2

    AST_NS_RR_HOLDS: assert property (@(posedge clk) disable iff (rst)
        acc_valid && !secure |=> $stable(rr_policy)); // R4

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !acc_valid |=> !undef && rd_data == '0); // R9

    AST_WRITE_NO_DATA: assert property (@(posedge clk) disable iff (rst)
        acc_valid && acc_write |=> rd_data == '0); // R9
endmodule

bind sysctl_reg sysctl_reg_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .acc_valid (acc_valid),
    .acc_write (acc_write),
    .priv      (priv),
    .secure    (secure),
    .lock      (lock),
    .rd_data   (rd_data),
    .undef     (undef),
    .rr_policy (rr_policy)
);

// File: tb/sysctl_reg_test.sv
module sysctl_reg_test;
    localparam logic [31:0] ONES   = 32'h00C5_0078;
    localparam logic [31:0] BANKED = 32'h7200_3C07;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        acc_valid = 1'b0, acc_write = 1'b0;
    logic [31:0] acc_wdata = '0;
    logic        priv = 1'b0, secure = 1'b0, lock = 1'b0;
    logic        strap_tstate = 1'b0, strap_bigend = 1'b0, strap_hivec = 1'b0, strap_nmi = 1'b0;
    logic [31:0] rd_data, vec_base;
    logic        undef, mmu_en, align_chk, dcache_en, icache_en, bpred_en, hi_vec;
    logic        exc_bigend, remap_en, afe_en, exc_tstate, rr_policy;

    int vectors = 0;
    int misses  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;

    sysctl_reg uut (
        .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_wdata(acc_wdata), .priv(priv), .secure(secure), .lock(lock),
        .strap_tstate(strap_tstate), .strap_bigend(strap_bigend),
        .strap_hivec(strap_hivec), .strap_nmi(strap_nmi),
        .rd_data(rd_data), .undef(undef), .mmu_en(mmu_en), .align_chk(align_chk),
        .dcache_en(dcache_en), .icache_en(icache_en), .bpred_en(bpred_en),
        .hi_vec(hi_vec), .exc_bigend(exc_bigend), .remap_en(remap_en),
        .afe_en(afe_en), .exc_tstate(exc_tstate), .rr_policy(rr_policy),
        .vec_base(vec_base)
    );

    // Reference model
    logic [31:0] mbank [2];
    logic        mrr, mnmi;

    typedef struct {
        logic [31:0] rd;
        logic        ud;
        string       tag;
    } exp_t;
    exp_t exp_q[$];

    function automatic logic [31:0] model_word(input logic s);
        return ONES | mbank[s] | (32'(mnmi) << 27) | (32'(mrr) << 14);
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    endtask

    // Monitor: compares registered results one cycle after each access
    always @(posedge clk) begin
        #5;
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            vectors++;
            if (rd_data !== e.rd || undef !== e.ud) begin
                misses++;
                $display("FAIL %s: rd_data=%h undef=%b expected rd_data=%h undef=%b",
                         e.tag, rd_data, undef, e.rd, e.ud);
            end
        end
    end

    task automatic do_reset(input bit t, input bit e, input bit h, input bit n);
        @(negedge clk);
        rst = 1'b1; acc_valid = 1'b0;
        strap_tstate = t; strap_bigend = e; strap_hivec = h; strap_nmi = n;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        for (int b = 0; b < 2; b++)
            mbank[b] = (32'(t) << 30) | (32'(e) << 25) | (32'(h) << 13);
        mrr  = 1'b0;
        mnmi = n;
    endtask

    task automatic acc(input bit v, input bit w, input logic [31:0] wd,
                       input bit p, input bit s, input bit lk, input string tag);
        logic [31:0] c;
        logic [43:0] got, expv;
        exp_t e;
        @(negedge clk);
        acc_valid = v; acc_write = w; acc_wdata = wd; priv = p; secure = s; lock = lk;
        #1;
        // R10 / R5 / R8: control outputs from the current copy
        c = mbank[s];
        expv = {c[0], c[1], c[2], c[11], c[12], c[13], c[25], c[28], c[29], c[30], mrr,
                (c[13] ? 32'hFFFF_0000 : 32'h0000_0000)};
        got  = {mmu_en, align_chk, dcache_en, bpred_en, icache_en, hi_vec, exc_bigend,
                remap_en, afe_en, exc_tstate, rr_policy, vec_base};
        vectors++;
        if (got !== expv) begin
            misses++;
            $display("FAIL R10 R5 R8 outputs (%s): got=%h expected=%h", tag, got, expv);
        end
        e.tag = tag;
        e.ud  = v && (!p || (w && s && lk));
        e.rd  = (v && !w && p) ? model_word(s) : 32'h0;
        exp_q.push_back(e);
        if (v && w && p && !(s && lk)) begin
            mbank[s] = wd & BANKED;
            if (s) mrr = wd[14];
        end
    endtask

    task automatic rd(input bit s, input string tag);
        acc(1'b1, 1'b0, 32'h0, 1'b1, s, 1'b0, tag);
    endtask

    task automatic wr(input bit s, input logic [31:0] d, input string tag);
        acc(1'b1, 1'b1, d, 1'b1, s, 1'b0, tag);
    endtask

    task automatic idle(input bit s, input string tag);
        acc(1'b0, 1'b0, 32'hDEAD_BEEF, 1'b1, s, 1'b0, tag);
    endtask

    initial begin
        #3_000_000;
        if (!done) begin
            misses++;
            $display("FAIL watchdog: run hung, expected completion");
            finish_run();
        end
    end

    initial begin
        do_reset(1'b1, 1'b0, 1'b1, 1'b1);
        rd(1'b1, "R1 secure reset value");
        rd(1'b0, "R1 nonsecure reset value");
        idle(1'b1, "R9 idle after read");

        wr(1'b1, 32'hFFFF_FFFF, "R2 R3 R4 secure write all ones");
        rd(1'b1, "R2 R3 R4 R5 secure readback");
        rd(1'b0, "R4 R5 nonsecure copy untouched, shares policy");

        wr(1'b0, 32'h0000_0000, "R4 nonsecure write zero");
        rd(1'b1, "R4 policy kept after nonsecure write");
        wr(1'b0, 32'h1234_5A5A, "R5 nonsecure pattern");
        rd(1'b0, "R5 nonsecure pattern readback");
        rd(1'b1, "R5 secure copy independent");

        acc(1'b1, 1'b1, 32'h0, 1'b0, 1'b1, 1'b0, "R6 user write secure");
        acc(1'b1, 1'b1, 32'hFFFF_FFFF, 1'b0, 1'b0, 1'b0, "R6 user write nonsecure");
        acc(1'b1, 1'b0, 32'h0, 1'b0, 1'b1, 1'b0, "R6 user read");
        rd(1'b1, "R6 secure unchanged");
        rd(1'b0, "R6 nonsecure unchanged");

        acc(1'b1, 1'b1, 32'h0, 1'b1, 1'b1, 1'b1, "R7 locked secure write");
        acc(1'b1, 1'b0, 32'h0, 1'b1, 1'b1, 1'b1, "R7 locked secure read allowed");
        acc(1'b1, 1'b1, 32'h0000_2001, 1'b1, 1'b0, 1'b1, "R7 locked nonsecure write allowed");
        rd(1'b0, "R7 nonsecure write landed");

        wr(1'b1, 32'h0000_0000, "R8 secure low vectors");
        idle(1'b1, "R8 low base");
        wr(1'b1, 32'h0000_2000, "R8 secure high vectors");
        idle(1'b1, "R8 high base");
        idle(1'b0, "R8 R10 nonsecure view");

        for (int i = 0; i < 8; i++) begin
            logic [31:0] pat;
            pat = 32'h1 << (i * 4) ^ 32'hA5A5_5A5A;
            wr(i[0], pat, "R5 R10 pattern write");
            rd(i[0], "R2 R5 pattern readback");
            idle(~i[0], "R9 R10 other view");
        end

        do_reset(1'b0, 1'b1, 1'b0, 1'b0);
        rd(1'b1, "R1 secure reset inverted straps");
        rd(1'b0, "R1 nonsecure reset inverted straps");
        wr(1'b1, 32'h0800_0000, "R3 write to read-only bit");
        rd(1'b1, "R3 read-only bit stays at strap");
        idle(1'b0, "R9 final idle");
        idle(1'b0, "R9 final idle");
        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule